// File: doc/BRIEF.md
# Two-Wire Bit-Rate Clock Generator

This block produces the serial clock timing for a two-wire port from a fast oscillator clock. A programmable oscillator divider first makes a machine-clock enable. A fixed divide-by-8 prescaler then feeds an auto-reload down-counter. An 8-bit frequency-select register sets the reload count, and software can write and read it back. Each serial clock period lasts eight machine cycles per reload count plus a fixed two machine cycles of reload overhead.

The block has two outputs. The first is a one-oscillator-cycle strobe that marks the start of every serial clock period. The second is a square-wave serial clock level, which is low for the first half of each period and high for the second half. While the enable is low, the clock level idles high and the timer stays loaded with the current register value. The first strobe after the enable rises begins a low phase. A register value of 0 selects the longest period. The illegal value 1 is replaced by 2, and a sticky flag reports it.

Top module: `twowire_rate_gen`

## Requirements
- R1: The machine cycle is 4 oscillator cycles when `div_sel` is 2'b00, 64 when it is 2'b01, and 1024 when it is 2'b10 or 2'b11.
- R2: For a register value R from 2 to 255, the strobe interval, and with it the serial clock period, is (8·R + 2) machine cycles.
- R3: A register value of 0 gives a reload count of 256, so the period is 2050 machine cycles.
- R4: A register value of 1 gives a reload count of 2 and sets `invalid` one cycle after the write. A later write of any other value clears `invalid`.
- R5: The register is 8 bits and resets to 8'h00. A write takes effect one cycle later, and `rd_data` then returns the value written, including 1.
- R6: A register write made while a period is running does not change that period. The new count applies from the next reload onward.
- R7: While `enable` is low, `scl_level` is 1 and `bit_strobe` stays 0. The first strobe after `enable` rises drives `scl_level` low.
- R8: In each period, `scl_level` is low for (4·Reload + 1) machine cycles, counted from the strobe, and then high until the next strobe.
- R9: `bit_strobe` is exactly one oscillator cycle wide, and it is high in the first cycle in which `scl_level` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_sel | input | 2 | Machine-clock divider select |
| enable | input | 1 | Runs the timer; when low, the clock idles high |
| wr_en | input | 1 | Frequency-select register write strobe |
| wr_data | input | 8 | Frequency-select write value |
| rd_data | output | 8 | Frequency-select register readback |
| invalid | output | 1 | Sticky flag set when the register holds 1 |
| bit_strobe | output | 1 | One-cycle pulse at the start of each serial clock period |
| scl_level | output | 1 | Square-wave serial clock level |

## Verification
The main patterns are a sweep of register values from 2 to 24 at the fast divider, plus the extreme values 0 and 255. Together they separate the 8·R+2 period law from an off-by-one in either the prescaler or the overhead, and they show whether the value 0 wraps to 256. The slower divider settings are tried at the shortest count, and each is measured in oscillator cycles, so any mix-up of the select encodings shows up as a wrong multiple. Separate runs cover the following:
- a register write in the middle of a period, which tells apart a reload taken at once from one deferred to the period boundary;
- the value 1, which shows both the substituted count and the flag behaviour;
- the low-phase length in every run, which checks that the waveform is symmetric about the midpoint.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int REG_W    = 8;
  localparam int LOAD_W   = REG_W + 1;
  localparam int PRESCALE = 8;
  localparam int PRE_W    = $clog2(PRESCALE);

  // Map a register value to the reload count: 0 -> 256, 1 -> 2, else as is.
  function automatic logic [LOAD_W-1:0] reload_of(input logic [REG_W-1:0] v);
    if (v == '0)
      return {1'b1, {REG_W{1'b0}}};
    else if (v == REG_W'(1))
      return LOAD_W'(2);
    else
      return {1'b0, v};
  endfunction
endpackage

// File: rtl/twr_mclk_div.sv
module twr_mclk_div #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 64,
  parameter int DIV_C = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  output logic       mclk_en
);
  localparam int CW = $clog2(DIV_C);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  always_comb begin
    case (div_sel)
      2'b00:   last = CW'(DIV_A - 1);
      2'b01:   last = CW'(DIV_B - 1);
      default: last = CW'(DIV_C - 1);
    endcase
  end

  assign mclk_en = (cnt_q >= last);

  always_comb begin
    cnt_d = mclk_en ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  mclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |=> !mclk_en);
endmodule

// File: rtl/twr_freq_reg.sv
module twr_freq_reg
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [LOAD_W-1:0] reload_eff,
  output logic              invalid
);
  logic [REG_W-1:0] reg_q, reg_d;
  logic             inv_q, inv_d;

  always_comb begin
    reg_d = reg_q;
    inv_d = inv_q;
    if (wr_en) begin
      reg_d = wr_data;
      inv_d = (wr_data == REG_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
      inv_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      inv_q <= inv_d;
    end
  end

  assign rd_data    = reg_q;
  assign invalid    = inv_q;
  assign reload_eff = reload_of(reg_q);

  // R4
  inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == REG_W'(1)) |=> invalid);

  // R5
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));
endmodule

// File: rtl/twr_reload_timer.sv
module twr_reload_timer
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mclk_en,
  input  logic [LOAD_W-1:0] reload_eff,
  output logic              period_end,
  output logic [LOAD_W-1:0] cur_load
);
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [LOAD_W-1:0] tmr_q, tmr_d;
  logic [LOAD_W-1:0] load_q, load_d;
  logic              ovh_q, ovh_d;
  logic              ovh2_q, ovh2_d;
  logic              pre_wrap;

  assign pre_wrap   = (pre_q == PRE_W'(PRESCALE - 1));
  assign period_end = enable & mclk_en & ovh_q & ovh2_q;
  assign cur_load   = load_q;

  always_comb begin
    pre_d  = pre_q;
    tmr_d  = tmr_q;
    load_d = load_q;
    ovh_d  = ovh_q;
    ovh2_d = ovh2_q;
    if (!enable) begin
      pre_d  = '0;
      tmr_d  = reload_eff;
      load_d = reload_eff;
      ovh_d  = 1'b0;
      ovh2_d = 1'b0;
    end else if (mclk_en) begin
      if (ovh_q) begin
        if (!ovh2_q) begin
          ovh2_d = 1'b1;
        end else begin
          ovh_d  = 1'b0;
          ovh2_d = 1'b0;
          pre_d  = '0;
          tmr_d  = reload_eff;
          load_d = reload_eff;
        end
      end else begin
        pre_d = pre_q + 1'b1;
        if (pre_wrap) begin
          if (tmr_q == LOAD_W'(1)) ovh_d = 1'b1;
          else                     tmr_d = tmr_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tmr_q  <= LOAD_W'(2);
      load_q <= LOAD_W'(2);
      ovh_q  <= 1'b0;
      ovh2_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      tmr_q  <= tmr_d;
      load_q <= load_d;
      ovh_q  <= ovh_d;
      ovh2_q <= ovh2_d;
    end
  end

  // R3
  tmr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q != '0);

  // R6
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable && !$past(period_end)) |-> $stable(cur_load));
endmodule

// File: rtl/twowire_rate_gen.sv
module twowire_rate_gen
  import twr_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 64,
  parameter int DIV_C = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  div_sel,
  input  logic        enable,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic        invalid,
  output logic        bit_strobe,
  output logic        scl_level
);
  localparam int HW = LOAD_W + 2;

  logic              mclk_en;
  logic [LOAD_W-1:0] reload_eff;
  logic [LOAD_W-1:0] cur_load;
  logic              period_end;
  logic [HW-1:0]     half_last;

  logic          scl_q, scl_d;
  logic          run_q, run_d;
  logic          stb_q;
  logic [HW-1:0] h_q, h_d;

  twr_mclk_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_div (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .mclk_en(mclk_en)
  );

  twr_freq_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .reload_eff(reload_eff), .invalid(invalid)
  );

  twr_reload_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mclk_en(mclk_en),
    .reload_eff(reload_eff), .period_end(period_end), .cur_load(cur_load)
  );

  // Low phase lasts 4*Reload+1 machine cycles; index of its last tick.
  assign half_last = {cur_load, 2'b00};

  always_comb begin
    scl_d = scl_q;
    run_d = run_q;
    h_d   = h_q;
    if (!enable) begin
      scl_d = 1'b1;
      run_d = 1'b0;
      h_d   = '0;
    end else if (period_end) begin
      scl_d = 1'b0;
      run_d = 1'b1;
      h_d   = '0;
    end else if (run_q && !scl_q && mclk_en) begin
      if (h_q == half_last) begin
        scl_d = 1'b1;
        h_d   = '0;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      run_q <= 1'b0;
      h_q   <= '0;
      stb_q <= 1'b0;
    end else begin
      scl_q <= scl_d;
      run_q <= run_d;
      h_q   <= h_d;
      stb_q <= period_end;
    end
  end

  assign scl_level  = scl_q;
  assign bit_strobe = stb_q;

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_level && !bit_strobe));

  // R9
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> !scl_level);

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
endmodule

// File: tb/twowire_rate_gen_tb.sv
module twowire_rate_gen_tb;
  logic       clk;
  logic       rst_n;
  logic [1:0] div_sel;
  logic       enable;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       invalid;
  logic       bit_strobe;
  logic       scl_level;

  int total, bad;
  int cyc;

  twowire_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .enable(enable),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .invalid(invalid), .bit_strobe(bit_strobe), .scl_level(scl_level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Wait at negedges for a strobe; returns cycle stamp, or -1 on timeout.
  task automatic wait_strobe(input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (bit_strobe) begin
        t = cyc;
        break;
      end
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    if (s == 2'b00) return 4;
    if (s == 2'b01) return 64;
    return 1024;
  endfunction

  // One configuration: period and low phase, measured in oscillator cycles.
  task automatic run_cfg(input string req, input logic [1:0] s,
                         input logic [7:0] v, input int r);
    int d, t1, t2, low;
    d = div_of(s);
    @(negedge clk);
    enable  = 1'b0;
    div_sel = s;
    write_reg(v);
    @(negedge clk);
    enable = 1'b1;
    wait_strobe((8*r+2)*d*2 + 2*d + 10, t1);
    if (t1 < 0) begin
      check({req, " first strobe timeout"}, 0, 1);
      return;
    end
    check("R9 scl low at strobe", int'(scl_level), 0);
    low = 0;
    while (!scl_level && low < (8*r+2)*d + 10) begin
      @(negedge clk);
      low++;
      if (low == 1) check("R9 strobe one cycle", int'(bit_strobe), 0);
    end
    check("R8 low phase", low, (4*r+1)*d);
    wait_strobe((8*r+2)*d + 10, t2);
    check({req, " period"}, t2 - t1, (8*r+2)*d);
  endtask

  initial begin
    int t1, t2, t3, hi_bad;
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; div_sel = 2'b00; enable = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 reset rd_data", int'(rd_data), 0);
    check("R4 reset invalid", int'(invalid), 0);
    check("R7 reset scl", int'(scl_level), 1);
    check("R9 reset strobe", int'(bit_strobe), 0);
    rst_n = 1'b1;

    // R7 enable low: idle high, no strobes
    write_reg(8'd2);
    hi_bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!scl_level || bit_strobe) hi_bad++;
    end
    check("R7 idle while disabled", hi_bad, 0);

    // R5 readback
    write_reg(8'hA5);
    check("R5 readback", int'(rd_data), 8'hA5);

    // R2 sweep at fast divider
    for (int r = 2; r <= 24; r++) run_cfg("R2", 2'b00, 8'(r), r);
    run_cfg("R2 max", 2'b00, 8'd255, 255);
    // R3 zero means 256
    run_cfg("R3", 2'b00, 8'd0, 256);
    // R1 other divider encodings
    run_cfg("R1 sel01", 2'b01, 8'd2, 2);
    run_cfg("R1 sel10", 2'b10, 8'd2, 2);

    // R4 illegal value 1
    enable = 1'b0;
    write_reg(8'd1);
    check("R4 readback of 1", int'(rd_data), 1);
    check("R4 invalid set", int'(invalid), 1);
    run_cfg("R4 treated as 2", 2'b00, 8'd1, 2);
    check("R4 invalid sticky", int'(invalid), 1);
    write_reg(8'd5);
    check("R4 invalid cleared", int'(invalid), 0);

    // R6 mid-period write deferred to next reload
    @(negedge clk);
    enable = 1'b0;
    div_sel = 2'b00;
    write_reg(8'd20);
    @(negedge clk);
    enable = 1'b1;
    wait_strobe(2000, t1);
    repeat (100) @(negedge clk);
    write_reg(8'd3);
    wait_strobe(2000, t2);
    wait_strobe(2000, t3);
    check("R6 running period kept", t2 - t1, 162*4);
    check("R6 new count next period", t3 - t2, 26*4);

    // R7 disable returns clock high
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R7 high after disable", int'(scl_level), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule